// File: doc/BRIEF.md
# SPI Master Channel

This block is a single SPI master channel that software drives through five registers: configuration, status, control, transmit data and receive data. It produces the serial clock from the block clock using a power-of-two exponent, and it supports every combination of clock polarity and clock phase. Word lengths run from 4 to 32 bits. Bits are sent MSB first. Three transfer modes are available: full duplex, transmit-only and receive-only. In receive-only mode, reading the receive register starts the next word, so a stream of words can be read with no transmit writes after the first.

Chip select comes from a software force bit and a programmable polarity. It is independent of channel enable. Each of the two data lines can be driven or left undriven, and either line can be chosen as the sampled input. Two DMA request outputs follow the empty and full flags. The shift sequencer has three named states. IDLE waits for a pending word. LEAD is the half bit in which data is driven and that ends with the sample. TRAIL is the second half bit. The transitions are:

- start: IDLE→LEAD
- sample: LEAD→TRAIL
- next bit: TRAIL→LEAD
- word end: TRAIL→IDLE
- abort: any state→IDLE when the channel is disabled

Top module: `spi_master_chan`

## Requirements
- R1: Each SCK half period lasts 2^E block-clock cycles, where E is the 4-bit exponent in configuration bits [5:2]. A word of L bits written at clock edge W finishes at edge W+1+L·2^(E+1). End-of-transfer is low one cycle before that edge and high after it.
- R2: While no word is shifting, SCK rests at the polarity bit (configuration bit 1). When the phase bit (bit 0) is 0, data is sampled on the leading edge; when it is 1, data is sampled on the trailing edge. Each word produces exactly 2·L SCK edges.
- R3: The length field in configuration bits [11:7] holds L−1, and any value below 3 gives L=4. Transmit bits are sent MSB first from bit L−1 of the written word downwards. The received word is zero-extended to 32 bits.
- R4: The status register has three bits: bit 0 is receive-full, bit 1 is transmit-empty and bit 2 is end-of-transfer. Writing the transmit register clears transmit-empty until the sequencer takes the word. Reading the receive register clears receive-full. End-of-transfer is low while a word is pending or shifting.
- R5: Transfer mode field value 00 (configuration bits [13:12]) is full duplex. The sampled word is placed in the receive register and sets receive-full.
- R6: In transmit-only mode (field value 10), the sampled word is discarded and receive-full stays 0.
- R7: In receive-only mode (field value 01), a transmit write starts the first word, and each read of the receive register starts one more word. A read made while the field holds 00 starts nothing.
- R8: Chip select is active only when the force bit (bit 20) and the enable bit (control bit 0) are both 1. With bit 6 set, chip select is active low; with bit 6 clear, it is active high.
- R9: The write DMA request equals enable AND bit 14 AND transmit-empty. The read DMA request equals enable AND bit 15 AND receive-full.
- R10: Line 0 is driven when bit 16 is 0, and line 1 is driven when bit 17 is 0. Both lines carry the same serial data. Line 1 is sampled when bit 18 is 1; otherwise line 0 is sampled.
- R11: Clearing the enable bit aborts any word, returns SCK to its idle level, and leaves transmit-empty and end-of-transfer at 1 and receive-full at 0. Transmit writes made while the channel is disabled are ignored.
- R12: The register addresses are: configuration 0, status 1, control 2, transmit 3, receive 4. Configuration reads back the written value with bits 19 and 31:21 forced to 0. Out of reset, configuration is 0 and status is 0b110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on receive register) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| sck | output | 1 | Serial clock |
| cs_pin | output | 1 | Chip select pin level |
| line0_out | output | 1 | Serial data driven on line 0 |
| line0_oe | output | 1 | Drive enable for line 0 |
| line0_in | input | 1 | Level sampled from line 0 |
| line1_out | output | 1 | Serial data driven on line 1 |
| line1_oe | output | 1 | Drive enable for line 1 |
| line1_in | input | 1 | Level sampled from line 1 |
| dma_wr_req | output | 1 | Request for the next transmit word |
| dma_rd_req | output | 1 | Request to collect the received word |

## Verification
Several properties are checked on every cycle by assertions:
- SCK and chip select rest at their idle levels while the channel is disabled.
- End-of-transfer is low whenever SCK is away from its idle level.
- Disabling the channel clears both data flags at once.
- Each DMA request is raised only when its flag agrees.

Other behaviour can only be shown by the bench scenarios. These include the exact word duration for each exponent, the sampling edge for all four clock modes, MSB-first order and zero extension at several lengths, and the auto-start chain of receive-only mode together with the mode switch that stops it.

// File: rtl/spi_chan_pkg.sv
package spi_chan_pkg;

    localparam int REG_CFG  = 0;
    localparam int REG_STAT = 1;
    localparam int REG_CTRL = 2;
    localparam int REG_TX   = 3;
    localparam int REG_RX   = 4;

    typedef enum logic [1:0] {
        XM_DUPLEX = 2'b00,
        XM_RXONLY = 2'b01,
        XM_TXONLY = 2'b10,
        XM_RSVD   = 2'b11
    } xmode_e;

    typedef enum logic [1:0] {
        SH_IDLE  = 2'b00,
        SH_LEAD  = 2'b01,
        SH_TRAIL = 2'b10
    } sh_state_e;

    // configuration word layout, MSB first
    typedef struct packed {
        logic [10:0] rsvd_hi;
        logic        force_cs;
        logic        rsvd19;
        logic        in_sel;
        logic        drv_off1;
        logic        drv_off0;
        logic        dma_rd;
        logic        dma_wr;
        xmode_e      mode;
        logic [4:0]  len_m1;
        logic        cs_low;
        logic [3:0]  div_exp;
        logic        cpol;
        logic        cpha;
    } cfg_t;

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
    parameter int EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [EXP_W-1:0] div_exp,
    output logic             half_end
);
    localparam int CNT_W = (1 << EXP_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    assign limit    = (CNT_W'(1) << div_exp) - CNT_W'(1);
    assign half_end = run && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || half_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/spi_word_engine.sv
module spi_word_engine
    import spi_chan_pkg::*;
#(
    parameter int DW    = 32,
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             pending,
    input  logic [DW-1:0]    load_word,
    input  logic [LEN_W-1:0] wlen,
    input  logic             half_end,
    input  logic             din,
    output logic             take,
    output logic             done,
    output logic [DW-1:0]    rx_word,
    output logic             dout,
    output logic             lead,
    output logic             trail,
    output logic             idle
);
    localparam int IDX_W = $clog2(DW);

    sh_state_e        state_q, state_d;
    logic [DW-1:0]    tx_sh_q, rx_sh_q;
    logic [LEN_W-1:0] bits_q;
    logic [IDX_W-1:0] msb_idx;
    logic             last_bit;

    assign msb_idx  = IDX_W'(wlen - LEN_W'(1));
    assign last_bit = (bits_q == LEN_W'(1));

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SH_IDLE:  if (enable && pending) state_d = SH_LEAD;
            SH_LEAD:  if (half_end) state_d = SH_TRAIL;
            SH_TRAIL: if (half_end) state_d = last_bit ? SH_IDLE : SH_LEAD;
            default:  state_d = SH_IDLE;
        endcase
        if (!enable) state_d = SH_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SH_IDLE;
        else        state_q <= state_d;
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh_q <= '0;
            rx_sh_q <= '0;
            bits_q  <= '0;
        end else if (take) begin
            tx_sh_q <= load_word;
            rx_sh_q <= '0;
            bits_q  <= wlen;
        end else if (state_q == SH_LEAD && half_end) begin
            rx_sh_q <= {rx_sh_q[DW-2:0], din};
        end else if (state_q == SH_TRAIL && half_end && !last_bit) begin
            tx_sh_q <= tx_sh_q << 1;
            bits_q  <= bits_q - LEN_W'(1);
        end
    end

    // outputs
    always_comb begin
        idle    = (state_q == SH_IDLE);
        lead    = (state_q == SH_LEAD);
        trail   = (state_q == SH_TRAIL);
        take    = idle && enable && pending;
        done    = trail && half_end && last_bit && enable;
        rx_word = rx_sh_q;
        dout    = idle ? 1'b0 : tx_sh_q[msb_idx];
    end
endmodule

// File: rtl/spi_master_chan.sv
module spi_master_chan
    import spi_chan_pkg::*;
#(
    parameter int DW    = 32,
    parameter int AW    = 3,
    parameter int EXP_W = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          sck,
    output logic          cs_pin,
    output logic          line0_out,
    output logic          line0_oe,
    input  logic          line0_in,
    output logic          line1_out,
    output logic          line1_oe,
    input  logic          line1_in,
    output logic          dma_wr_req,
    output logic          dma_rd_req
);
    localparam int LEN_W = $clog2(DW) + 1;

    cfg_t             cfg_q, cfg_wr;
    logic             en_q, en_d;
    logic [DW-1:0]    tx_buf_q, rx_buf_q, load_word, rx_word;
    logic             tx_full_q, rx_full_q, auto_q;
    logic [LEN_W-1:0] wl_eff;
    logic             take, done, dout, lead, trail, idle, half_end, din;
    logic             eot_w, txs_w, rxs_w, cs_active;
    logic             wr_cfg, wr_ctrl, wr_tx, rd_rx;

    assign wr_cfg  = reg_wr && (reg_addr == AW'(REG_CFG));
    assign wr_ctrl = reg_wr && (reg_addr == AW'(REG_CTRL));
    assign wr_tx   = reg_wr && (reg_addr == AW'(REG_TX));
    assign rd_rx   = reg_rd && (reg_addr == AW'(REG_RX));

    assign en_d = wr_ctrl ? reg_wdata[0] : en_q;

    always_comb begin
        cfg_wr         = cfg_t'(reg_wdata[31:0]);
        cfg_wr.rsvd_hi = '0;
        cfg_wr.rsvd19  = 1'b0;
    end

    assign wl_eff    = (cfg_q.len_m1 < 5'd3) ? LEN_W'(4)
                                             : LEN_W'(cfg_q.len_m1) + LEN_W'(1);
    assign load_word = tx_full_q ? tx_buf_q : '0;
    assign din       = cfg_q.in_sel ? line1_in : line0_in;

    // register state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            en_q      <= 1'b0;
            tx_buf_q  <= '0;
            rx_buf_q  <= '0;
            tx_full_q <= 1'b0;
            rx_full_q <= 1'b0;
            auto_q    <= 1'b0;
        end else begin
            if (wr_cfg) cfg_q <= cfg_wr;
            en_q <= en_d;
            if (!en_d) begin
                tx_full_q <= 1'b0;
                rx_full_q <= 1'b0;
                auto_q    <= 1'b0;
            end else begin
                if (take) begin
                    tx_full_q <= 1'b0;
                    auto_q    <= 1'b0;
                end
                if (wr_tx) begin
                    tx_buf_q  <= reg_wdata;
                    tx_full_q <= 1'b1;
                end
                if (rd_rx) begin
                    rx_full_q <= 1'b0;
                    if (cfg_q.mode == XM_RXONLY) auto_q <= 1'b1;
                end
                if (done && cfg_q.mode != XM_TXONLY) begin
                    rx_buf_q  <= rx_word;
                    rx_full_q <= 1'b1;
                end
            end
        end
    end

    spi_half_timer #(.EXP_W(EXP_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (lead | trail),
        .div_exp  (cfg_q.div_exp),
        .half_end (half_end)
    );

    spi_word_engine #(.DW(DW), .LEN_W(LEN_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (en_d),
        .pending   (tx_full_q | auto_q),
        .load_word (load_word),
        .wlen      (wl_eff),
        .half_end  (half_end),
        .din       (din),
        .take      (take),
        .done      (done),
        .rx_word   (rx_word),
        .dout      (dout),
        .lead      (lead),
        .trail     (trail),
        .idle      (idle)
    );

    // status and pins
    assign txs_w     = !tx_full_q;
    assign rxs_w     = rx_full_q;
    assign eot_w     = idle && !tx_full_q && !auto_q;
    assign cs_active = en_q && cfg_q.force_cs;
    assign cs_pin    = cfg_q.cs_low ? !cs_active : cs_active;

    always_comb begin
        if (lead)       sck = cfg_q.cpol ^ cfg_q.cpha;
        else if (trail) sck = cfg_q.cpol ^ !cfg_q.cpha;
        else            sck = cfg_q.cpol;
    end

    assign line0_out  = dout;
    assign line1_out  = dout;
    assign line0_oe   = en_q && !cfg_q.drv_off0;
    assign line1_oe   = en_q && !cfg_q.drv_off1;
    assign dma_wr_req = en_q && cfg_q.dma_wr && txs_w;
    assign dma_rd_req = en_q && cfg_q.dma_rd && rxs_w;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            AW'(REG_CFG):  reg_rdata = DW'(cfg_q);
            AW'(REG_STAT): reg_rdata = DW'({eot_w, txs_w, rxs_w});
            AW'(REG_CTRL): reg_rdata = DW'(en_q);
            AW'(REG_TX):   reg_rdata = tx_buf_q;
            AW'(REG_RX):   reg_rdata = rx_buf_q;
            default:       reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_master_chan_chk.sv
module spi_master_chan_chk
    import spi_chan_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic en,
    input cfg_t cfg,
    input logic sck,
    input logic cs_pin,
    input logic eot,
    input logic tx_full,
    input logic rx_full,
    input logic dma_wr_req,
    input logic dma_rd_req
);
    assert_sck_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |-> (sck == cfg.cpol));

    assert_cs_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |-> (cs_pin == cfg.cs_low));

    assert_eot_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sck != cfg.cpol) |-> !eot);

    assert_disable_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en) |-> (!tx_full && !rx_full && eot));

    assert_dma_rd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rd_req |-> (rx_full && en));

    assert_dma_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_wr_req |-> (!tx_full && en));
endmodule

bind spi_master_chan spi_master_chan_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en_q),
    .cfg        (cfg_q),
    .sck        (sck),
    .cs_pin     (cs_pin),
    .eot        (eot_w),
    .tx_full    (tx_full_q),
    .rx_full    (rx_full_q),
    .dma_wr_req (dma_wr_req),
    .dma_rd_req (dma_rd_req)
);

// File: tb/spi_master_chan_tb.sv
module spi_master_chan_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sck, cs_pin, l0_out, l0_oe, l1_out, l1_oe, dma_wr, dma_rd;
    logic        l1_in = 1'b0;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    bit          mon_on = 0;
    logic        mon_pol = 0, mon_pha = 0;
    int          mon_edges = 0;
    logic [31:0] mon_word = '0;

    localparam int STD = (1 << 6) | (1 << 16) | (1 << 20);

    always #2 clk = ~clk;

    spi_master_chan u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sck(sck), .cs_pin(cs_pin),
        .line0_out(l0_out), .line0_oe(l0_oe), .line0_in(l1_out),
        .line1_out(l1_out), .line1_oe(l1_oe), .line1_in(l1_in),
        .dma_wr_req(dma_wr), .dma_rd_req(dma_rd)
    );

    // bench slave: samples line 1 on the sampling edge of the selected mode
    always @(sck) begin
        if (mon_on) begin
            mon_edges = mon_edges + 1;
            if ((sck != mon_pol) != mon_pha) mon_word = {mon_word[30:0], l1_out};
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = 3'(a); reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input int a, output logic [31:0] d);
        reg_addr = 3'(a); reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic peek(input int a, output logic [31:0] d);
        reg_addr = 3'(a); reg_rd = 1'b0;
        #1 d = reg_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] mkcfg(input int pha, input int pol, input int ex,
                                          input int lm1, input int mode, input int extra);
        return 32'(extra | pha | (pol << 1) | (ex << 2) | (lm1 << 7) | (mode << 12));
    endfunction

    function automatic logic [31:0] lmask(input int len);
        logic [63:0] m;
        m = (64'd1 << len) - 64'd1;
        return m[31:0];
    endfunction

    // one full-duplex style word with timing, edge, order and data checks
    task automatic run_word(input int pha, input int pol, input int lm1, input int ex,
                            input int len, input int extra, input logic [31:0] data,
                            input logic [31:0] exp_rx);
        logic [31:0] s;
        int n;
        reg_write(0, mkcfg(pha, pol, ex, lm1, 0, extra));
        mon_pol = 1'(pol); mon_pha = 1'(pha); mon_edges = 0; mon_word = '0; mon_on = 1;
        reg_write(3, data);
        peek(1, s); check("R4 txs clear after tx write", 32'(s[1]), 0);
        n = 1 + len * (2 << ex);
        wait_cyc(n - 1);
        peek(1, s); check("R1 eot low one cycle before end", 32'(s[2]), 0);
        wait_cyc(1);
        peek(1, s); check("R1 eot high at word end", 32'(s[2]), 1);
        check("R5 rxs set at word end", 32'(s[0]), 1);
        mon_on = 0;
        check("R2 sck edge count", 32'(mon_edges), 32'(2 * len));
        check("R3 msb-first data seen on sampling edge", mon_word, data & lmask(len));
        reg_read(4, s); check("R5 R3 received word", s, exp_rx);
        peek(1, s); check("R4 rxs cleared by read", 32'(s[0]), 0);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] s;
        int n;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // reset state
        peek(1, s); check("R12 status after reset", s, 32'h6);
        peek(0, s); check("R12 config after reset", s, 0);
        check("R2 sck idle after reset", 32'(sck), 0);
        check("R8 cs after reset", 32'(cs_pin), 0);
        check("R9 dma after reset", 32'({dma_wr, dma_rd}), 0);
        check("R10 lines undriven when disabled", 32'({l0_oe, l1_oe}), 0);

        // register map
        reg_write(0, 32'hFFFF_FFFF);
        peek(0, s); check("R12 config readback", s, 32'h0017_FFFF);
        reg_write(3, 32'h1234_5678);
        peek(1, s); check("R11 tx write ignored while disabled", s, 32'h6);

        // chip select
        reg_write(0, STD);
        check("R8 force without enable", 32'(cs_pin), 1);
        reg_write(0, (1 << 6) | (1 << 16));
        reg_write(2, 1);
        peek(2, s); check("R12 control readback", s, 1);
        check("R8 enable without force", 32'(cs_pin), 1);
        reg_write(0, STD);
        check("R8 force and enable active low", 32'(cs_pin), 0);
        reg_write(0, (1 << 16) | (1 << 20));
        check("R8 active high polarity", 32'(cs_pin), 1);

        // sweep: 4 clock modes x 5 lengths x 3 exponents
        for (int pha = 0; pha < 2; pha++)
            for (int pol = 0; pol < 2; pol++)
                for (int li = 0; li < 5; li++)
                    for (int ex = 0; ex < 3; ex++) begin
                        int len;
                        logic [31:0] d;
                        len = (li == 0) ? 4 : (li == 1) ? 5 : (li == 2) ? 8 : (li == 3) ? 13 : 32;
                        d = 32'hA5C3_96E1 ^ (32'(pha * 37 + pol * 11 + li * 5 + ex) * 32'h1357_9BDF);
                        run_word(pha, pol, len - 1, ex, len, STD, d, d & lmask(len));
                    end

        // short length field clamps to 4
        run_word(0, 0, 1, 0, 4, STD, 32'hFFFF_FFF6, 32'h6);

        // transmit-only discards received data
        reg_write(0, mkcfg(0, 0, 0, 7, 2, STD));
        reg_write(3, 32'h5A);
        wait_cyc(1 + 8 * 2);
        peek(1, s); check("R6 tx-only: eot set, rxs stays clear", s, 32'h6);

        // receive-only auto start
        reg_write(0, mkcfg(1, 0, 1, 7, 1, STD));
        reg_write(3, 0);
        n = 1 + 8 * 4;
        wait_cyc(n);
        peek(1, s); check("R7 first rx-only word done", s, 32'h7);
        reg_read(4, s);
        peek(1, s); check("R7 read starts next word", 32'(s[2]), 0);
        wait_cyc(n);
        peek(1, s); check("R7 second word received", s, 32'h7);
        reg_write(0, mkcfg(1, 0, 1, 7, 0, STD));
        reg_read(4, s);
        wait_cyc(4);
        peek(1, s); check("R7 read in duplex mode starts nothing", s, 32'h6);
        check("R2 sck idle after rx-only stop", 32'(sck), 0);

        // DMA requests
        reg_write(0, mkcfg(0, 0, 0, 7, 0, STD | (1 << 14) | (1 << 15)));
        check("R9 write request while empty", 32'({dma_wr, dma_rd}), 32'h2);
        reg_write(3, 32'hC3);
        check("R9 write request drops on tx write", 32'(dma_wr), 0);
        wait_cyc(1);
        check("R9 write request back after load", 32'(dma_wr), 1);
        wait_cyc(8 * 2);
        check("R9 read request on full", 32'(dma_rd), 1);
        reg_read(4, s);
        check("R5 dma word value", s, 32'hC3);
        check("R9 read request drops after read", 32'(dma_rd), 0);

        // line drive and input select
        reg_write(0, mkcfg(0, 0, 0, 7, 0, (1 << 6) | (1 << 17) | (1 << 20)));
        check("R10 drive line 0 only", 32'({l0_oe, l1_oe}), 32'h2);
        reg_write(0, STD);
        check("R10 drive line 1 only", 32'({l0_oe, l1_oe}), 32'h1);
        l1_in = 1'b1;
        run_word(0, 0, 7, 0, 8, STD | (1 << 18), 32'h0000_0042, 32'h0000_00FF);
        l1_in = 1'b0;

        // disable mid-word
        reg_write(0, mkcfg(0, 1, 2, 31, 0, STD));
        reg_write(3, 32'hDEAD_BEEF);
        wait_cyc(20);
        peek(1, s); check("R4 eot low mid-word", 32'(s[2]), 0);
        reg_write(2, 0);
        peek(1, s); check("R11 flags after disable", s, 32'h6);
        check("R11 sck idle after disable", 32'(sck), 1);
        check("R8 cs inactive after disable", 32'(cs_pin), 1);
        reg_write(3, 32'h0F0F_0F0F);
        peek(1, s); check("R11 tx write ignored while disabled", s, 32'h6);
        reg_write(2, 1);
        wait_cyc(3);
        peek(1, s); check("R11 no word after re-enable", s, 32'h6);
        check("R2 sck idle after re-enable", 32'(sck), 1);

        finished = 1;
        summary();
        $finish;
    end
endmodule